// File: doc/BRIEF.md
# Interrupt Rate Throttle

This block sits between an interrupt cause register, already ANDed with its mask, and a level-sensitive interrupt line. It lets the first rising edge through. At that edge it computes a hold-off window, measured in ticks of a 256 ns time base. While the window is open, any further rising edge is held back. When the window closes, the pending vector is evaluated again.

Three quantities can supply the window length:

- a general throttle interval, counted in 256 ns units;
- a receive hold-off, counted in 1024 ns units and armed only when a separate receive timer register is nonzero;
- a transmit hold-off, counted in 1024 ns units and armed only when the transmit path has flagged a descriptor that requests delayed interrupts.

The smallest nonzero candidate that applies at the edge sets the window. A candidate of zero is never chosen. A mitigation-disable input bypasses the computation.

Top module: `irq_throttle`

## Requirements
- R1: After reset the interrupt output is low, no window is open, the transmit delay flag is clear and all four delay registers read back as zero.
- R2: A write stores only bits 15:0 of `wr_data` into the register chosen by `wr_sel` (0 throttle, 1 receive hold-off, 2 transmit hold-off, 3 receive timer). `rd_data` shows that register with bits 31:16 reading zero.
- R3: With no window open, `irq` follows the OR of `pend` one cycle later. A rising edge outside a window is therefore passed on.
- R4: When `pend` becomes all zero, `irq` falls on the next cycle, even while a window is open.
- R5: A nonzero delay computed at a passed rising edge opens a window of that many `tick` pulses. A rising edge during the window keeps `irq` low. Once the last tick closes the window, `pend` is evaluated again and `irq` rises one cycle later if anything is pending.
- R6: The transmit candidate is four times the transmit hold-off register. It applies only if the delay flag is set and pend bit 0 (descriptor written) or bit 1 (queue empty) is set.
- R7: The receive candidate is four times the receive hold-off register. It applies only if the receive timer register is nonzero and pend bit 7 (receive timer) is set.
- R8: The window length is the smallest nonzero candidate among the transmit, receive and throttle candidates. If all candidates are zero, no window opens.
- R9: An `ide_set` pulse sets the delay flag. Every delay computation clears the flag.
- R10: While `mit_dis` is high, no window is opened and rising edges pass through directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse every 256 ns |
| pend | input | CAUSE_W | Cause vector ANDed with mask |
| ide_set | input | 1 | Transmit descriptor requested delayed interrupt |
| mit_dis | input | 1 | Bypass the delay computation |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with its default parameters: a 32-bit cause vector, a 24-bit window counter, and cause bits 0, 1 and 7 for the transmit and receive causes. It programs delay values of at most 20. Windows therefore stay short enough to count tick by tick, and each candidate rule, each minimum selection and each all-zero case produces an exact window length that the bench compares against.

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int CAUSE_W  = 32,
  parameter int CNT_W    = 24,
  parameter int TXDW_BIT = 0,
  parameter int TXQE_BIT = 1,
  parameter int RXT_BIT  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [CAUSE_W-1:0] pend,
  input  logic               ide_set,
  input  logic               mit_dis,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic               irq
);
  localparam int DLY_W = 18;

  logic [15:0] thr_q, rxa_q, txa_q, rxt_q;
  logic ide_q, win_q, irq_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [DLY_W-1:0] pick(input logic [DLY_W-1:0] a, input logic [DLY_W-1:0] b);
    if (a == '0) return b;
    if (b == '0) return a;
    return (a < b) ? a : b;
  endfunction

  wire any  = |pend;
  wire rise = !irq_q && any;
  wire calc = rise && !win_q && !mit_dis;

  wire [DLY_W-1:0] c_tx  = (ide_q && (pend[TXDW_BIT] || pend[TXQE_BIT])) ? {txa_q, 2'b00} : '0;
  wire [DLY_W-1:0] c_rx  = ((rxt_q != 16'd0) && pend[RXT_BIT]) ? {rxa_q, 2'b00} : '0;
  wire [DLY_W-1:0] c_thr = {2'b00, thr_q};
  wire [DLY_W-1:0] dly   = pick(pick(c_tx, c_rx), c_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      ide_q <= 1'b0;
      win_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      irq_q <= (rise && win_q) ? 1'b0 : any;
      ide_q <= (ide_q && !calc) || ide_set;
      if (calc && dly != '0) begin
        win_q <= 1'b1;
        cnt_q <= CNT_W'(dly);
      end else if (win_q && tick) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) win_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
      rxa_q <= '0;
      txa_q <= '0;
      rxt_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: thr_q <= wr_data[15:0];
        2'd1: rxa_q <= wr_data[15:0];
        2'd2: txa_q <= wr_data[15:0];
        default: rxt_q <= wr_data[15:0];
      endcase
    end
  end

  always_comb begin
    case (wr_sel)
      2'd0: rd_data = {16'd0, thr_q};
      2'd1: rd_data = {16'd0, rxa_q};
      2'd2: rd_data = {16'd0, txa_q};
      default: rd_data = {16'd0, rxt_q};
    endcase
  end

  assign irq = irq_q;

  p_fall_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !any |=> !irq_q);
  p_hold_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !irq_q && any) |=> !irq_q);
  p_open_with_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_q) |-> irq_q);
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ide_set |=> ide_q);
  p_no_open_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mit_dis && !win_q) |=> !win_q);
endmodule

// File: tb/test_irq_throttle.sv
module test_irq_throttle;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ide_set = 1'b0, mit_dis = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = '0, pend = '0, rd_data;
  logic irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  irq_throttle i_irq_throttle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pend(pend), .ide_set(ide_set),
    .mit_dis(mit_dis), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq));

  // thr, rx hold-off, tx hold-off, rx timer, ide, pend, expected ticks
  typedef struct packed {
    logic [15:0] thr, rxa, txa, rxt;
    logic        ide;
    logic [31:0] pv;
    logic [15:0] exp;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{16'd5,  16'd0, 16'd0, 16'd0, 1'b0, 32'h80, 16'd5},   // R5
    '{16'd0,  16'd0, 16'd3, 16'd0, 1'b1, 32'h01, 16'd12},  // R6
    '{16'd0,  16'd0, 16'd3, 16'd0, 1'b0, 32'h01, 16'd0},   // R6 no flag
    '{16'd0,  16'd0, 16'd3, 16'd0, 1'b1, 32'h80, 16'd0},   // R6 wrong cause
    '{16'd0,  16'd2, 16'd0, 16'd1, 1'b0, 32'h80, 16'd8},   // R7
    '{16'd0,  16'd2, 16'd0, 16'd0, 1'b0, 32'h80, 16'd0},   // R7 timer zero
    '{16'd20, 16'd2, 16'd0, 16'd1, 1'b0, 32'h80, 16'd8},   // R8
    '{16'd6,  16'd0, 16'd3, 16'd0, 1'b1, 32'h02, 16'd6},   // R8
    '{16'd0,  16'd0, 16'd0, 16'd0, 1'b0, 32'h81, 16'd0},   // R8 all zero
    '{16'd9,  16'd1, 16'd1, 16'd5, 1'b1, 32'h81, 16'd4}    // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; pend = '0; ide_set = 1'b0; tick = 1'b0;
    cyc(2); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d; cyc(1); wr_en = 1'b0;
  endtask

  // ticks needed before irq rises after re-raising pend; 0 means no window
  task automatic measure(input logic [31:0] pv, output int n);
    pend = '0; cyc(1);
    pend = pv; cyc(2);
    n = 0;
    while (!irq && n < 200) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(2);
      n++;
    end
  endtask

  task automatic arm(input logic [31:0] pv, input string req);
    pend = pv; cyc(1);
    check(req, {31'd0, irq}, 32'd1);
  endtask

  initial begin
    int n;
    do_reset();
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      wr_sel = 2'(s); cyc(1);
      check("R1 reg", rd_data, 32'd0);
    end
    wr(2'd0, 32'hABCD1234); wr_sel = 2'd0; cyc(1);
    check("R2 thr", rd_data, 32'h00001234);
    wr(2'd3, 32'hFFFF0001); wr_sel = 2'd3; cyc(1);
    check("R2 rxt", rd_data, 32'h00000001);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd0, {16'd0, VT[i].thr});
      wr(2'd1, {16'd0, VT[i].rxa});
      wr(2'd2, {16'd0, VT[i].txa});
      wr(2'd3, {16'd0, VT[i].rxt});
      if (VT[i].ide) begin ide_set = 1'b1; cyc(1); ide_set = 1'b0; end
      arm(VT[i].pv, "R3 edge passes");
      pend = '0; cyc(1);
      check("R4 fall", {31'd0, irq}, 32'd0);
      measure(VT[i].pv, n);
      check($sformatf("R5/R6/R7/R8 vector %0d window", i), n, {16'd0, VT[i].exp});
    end

    // R9: flag cleared by computation, second window has no tx candidate
    do_reset();
    wr(2'd2, 32'd3);
    ide_set = 1'b1; cyc(1); ide_set = 1'b0;
    arm(32'h01, "R9 first edge");
    measure(32'h01, n);
    check("R9 first window", n, 32'd12);
    measure(32'h01, n);
    check("R9 flag cleared", n, 32'd0);

    // R4 during an open window
    do_reset();
    wr(2'd0, 32'd10);
    arm(32'h80, "R4 arm");
    pend = '0; cyc(1);
    check("R4 fall in window", {31'd0, irq}, 32'd0);
    pend = 32'h80; cyc(2);
    check("R5 held in window", {31'd0, irq}, 32'd0);

    // R10
    do_reset();
    mit_dis = 1'b1;
    wr(2'd0, 32'd5);
    arm(32'h80, "R10 edge");
    measure(32'h80, n);
    check("R10 bypass", n, 32'd0);
    mit_dis = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule